// File: doc/BRIEF.md
# Dual-Port Semaphore Latch Bank

This block holds a small bank of hardware semaphores that two independent ports, called left and right, use to claim shared resources. Each semaphore is separate from any memory and is picked by a short address. A port asks for a semaphore by writing a 0 and gives it back by writing a 1. Reading a semaphore tells the port whether it holds it: a 0 means "yours", a 1 means "not yours" (free or held by the other side).

A port may ask for a semaphore that the other side already holds. The request is stored. The moment the holder gives the semaphore back, ownership moves straight to the waiting port without any further access. A waiting port can withdraw its request by writing a 1. Both ports share one clock. The reset input is asynchronous and active-low, and the block releases it in step with the clock.

Top module: `dp_sem_bank`

## Requirements
- R1: After reset every semaphore is free with no stored request, and both read outputs show 1.
- R2: A write (select and write strobe high) of data 0 to a free semaphore makes the writing port its owner. That port then reads 0 and the other port reads 1.
- R3: A free semaphore reads 1 on both ports.
- R4: A write of 0 by the port that does not own a held semaphore leaves what both ports read unchanged. The request is stored.
- R5: When the owner writes 1 and the other port has a stored request, ownership passes to the other port at that same clock edge.
- R6: When the owner writes 1 and no request is stored, the semaphore becomes free.
- R7: A port that writes 1 to a semaphore it does not own withdraws its stored request. A later release by the owner then leaves the semaphore free.
- R8: If both ports write 0 to the same free semaphore in one cycle, the left port becomes owner and the right port's request is stored.
- R9: The read output is a register. It is loaded at the clock edge where select and read strobe are both high, with the state as it stood before any write at that edge. A write at one edge is therefore seen by a read strobed in the next cycle. Without a read strobe the output holds its value.
- R10: A write changes only the semaphore at its own address.
- R11: A write strobe without the port's select has no effect on any semaphore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel | input | 1 | Left port semaphore select |
| l_wr | input | 1 | Left port write strobe |
| l_rd | input | 1 | Left port read strobe |
| l_addr | input | 3 | Left port semaphore address |
| l_wdata | input | 1 | Left port write value (0 requests, 1 releases) |
| l_rdata | output | 1 | Left port read value (0 means owned by left) |
| r_sel | input | 1 | Right port semaphore select |
| r_wr | input | 1 | Right port write strobe |
| r_rd | input | 1 | Right port read strobe |
| r_addr | input | 3 | Right port semaphore address |
| r_wdata | input | 1 | Right port write value (0 requests, 1 releases) |
| r_rdata | output | 1 | Right port read value (0 means owned by right) |

## Verification
Every result appears one edge after its stimulus. A write changes the semaphore state at the edge where it is strobed. A read strobed in the same cycle registers the state from before that edge, and the read output shows it right after that edge. The bench drives each cycle's inputs on the falling edge and then waits one full cycle. Before the edge it computes the expected read values from its model state, and only after that does it apply the cycle's writes to the model. It compares both read outputs on the next falling edge. This holds for directed sequences (grant, pending transfer, cancel, same-cycle tie) and for random traffic on a narrowed address range that forces collisions.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    SEM_FREE  = 2'd0,
    SEM_LEFT  = 2'd1,
    SEM_RIGHT = 2'd2
  } sem_owner_e;
endpackage

// File: rtl/sem_rst_sync.sv
module sem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int NUM_SEM = 8,
  localparam int AW = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               wr,
  input  logic [AW-1:0]      addr,
  output logic [NUM_SEM-1:0] hit
);
  always_comb begin
    hit = '0;
    if (sel && wr) hit[addr] = 1'b1;
  end

  // R10: a write reaches at most one semaphore
  assert_single_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R11: no target without select
  assert_no_target_unselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (hit == '0));
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_l,
  input  logic val_l,
  input  logic wr_r,
  input  logic val_r,
  output logic held_l,
  output logic held_r
);
  sem_owner_e owner_q, owner_d;
  logic       req_l_q, req_l_d;
  logic       req_r_q, req_r_d;
  logic       upd_en;

  assign upd_en = wr_l | wr_r;

  always_comb begin
    req_l_d = wr_l ? ~val_l : req_l_q;
    req_r_d = wr_r ? ~val_r : req_r_q;
    case (owner_q)
      SEM_LEFT:  owner_d = req_l_d ? SEM_LEFT  : (req_r_d ? SEM_RIGHT : SEM_FREE);
      SEM_RIGHT: owner_d = req_r_d ? SEM_RIGHT : (req_l_d ? SEM_LEFT  : SEM_FREE);
      default:   owner_d = req_l_d ? SEM_LEFT  : (req_r_d ? SEM_RIGHT : SEM_FREE);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= SEM_FREE;
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
    end else if (upd_en) begin
      owner_q <= owner_d;
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
    end
  end

  assign held_l = (owner_q == SEM_LEFT);
  assign held_r = (owner_q == SEM_RIGHT);

  // R4: owner keeps the token unless it writes 1
  assert_left_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == SEM_LEFT && !(wr_l && val_l)) |=> (owner_q == SEM_LEFT));
  assert_right_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == SEM_RIGHT && !(wr_r && val_r)) |=> (owner_q == SEM_RIGHT));

  // R5: release with a live waiter hands over at once
  assert_handover_to_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == SEM_LEFT && wr_l && val_l && req_r_q && !(wr_r && val_r))
      |=> (owner_q == SEM_RIGHT));
  assert_handover_to_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == SEM_RIGHT && wr_r && val_r && req_l_q && !(wr_l && val_l))
      |=> (owner_q == SEM_LEFT));

  // R6: a free semaphore has no waiter
  assert_free_no_waiter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == SEM_FREE) |-> (!req_l_q && !req_r_q));

  // R8: tie on a free semaphore goes left
  assert_tie_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == SEM_FREE && wr_l && !val_l && wr_r && !val_r)
      |=> (owner_q == SEM_LEFT && req_r_q));
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
  parameter int NUM_SEM = 8,
  localparam int AW = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               rd,
  input  logic [AW-1:0]      addr,
  input  logic [NUM_SEM-1:0] held_mine,
  output logic               rdata
);
  logic rd_en;
  logic rdata_d;

  assign rd_en   = sel & rd;
  assign rdata_d = ~held_mine[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 1'b1;
    else if (rd_en) rdata <= rdata_d;
  end

  // R9: output holds without a read strobe
  assert_hold_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/dp_sem_bank.sv
module dp_sem_bank #(
  parameter int NUM_SEM = 8,
  localparam int AW = $clog2(NUM_SEM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sel,
  input  logic          l_wr,
  input  logic          l_rd,
  input  logic [AW-1:0] l_addr,
  input  logic          l_wdata,
  output logic          l_rdata,
  input  logic          r_sel,
  input  logic          r_wr,
  input  logic          r_rd,
  input  logic [AW-1:0] r_addr,
  input  logic          r_wdata,
  output logic          r_rdata
);
  logic               rst_n_i;
  logic [NUM_SEM-1:0] hit_l, hit_r;
  logic [NUM_SEM-1:0] held_l, held_r;

  sem_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  sem_port_dec #(.NUM_SEM(NUM_SEM)) u_dec_l (
    .clk(clk), .rst_n(rst_n_i), .sel(l_sel), .wr(l_wr), .addr(l_addr), .hit(hit_l)
  );
  sem_port_dec #(.NUM_SEM(NUM_SEM)) u_dec_r (
    .clk(clk), .rst_n(rst_n_i), .sel(r_sel), .wr(r_wr), .addr(r_addr), .hit(hit_r)
  );

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem
    sem_cell u_cell (
      .clk(clk), .rst_n(rst_n_i),
      .wr_l(hit_l[g]), .val_l(l_wdata),
      .wr_r(hit_r[g]), .val_r(r_wdata),
      .held_l(held_l[g]), .held_r(held_r[g])
    );
  end

  sem_read_port #(.NUM_SEM(NUM_SEM)) u_rd_l (
    .clk(clk), .rst_n(rst_n_i), .sel(l_sel), .rd(l_rd), .addr(l_addr),
    .held_mine(held_l), .rdata(l_rdata)
  );
  sem_read_port #(.NUM_SEM(NUM_SEM)) u_rd_r (
    .clk(clk), .rst_n(rst_n_i), .sel(r_sel), .rd(r_rd), .addr(r_addr),
    .held_mine(held_r), .rdata(r_rdata)
  );

  // R2, R3: never owned by both sides at once
  assert_exclusive_owner_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (held_l & held_r) == '0);
endmodule

// File: tb/tb_dp_sem_bank.sv
module tb_dp_sem_bank;
  logic clk = 1'b0;
  logic rst_n;
  logic l_sel, l_wr, l_rd, l_wdata, r_sel, r_wr, r_rd, r_wdata;
  logic [2:0] l_addr, r_addr;
  logic l_rdata, r_rdata;

  int n_run  = 0;
  int n_fail = 0;

  // model: 0 free, 1 left, 2 right
  int m_own [8];
  bit m_ql  [8];
  bit m_qr  [8];
  logic exp_l, exp_r;

  always #5 clk = ~clk;

  dp_sem_bank dut (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_wr(r_wr), .r_rd(r_rd), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  function automatic logic view(int own, int port);
    return (own == port) ? 1'b0 : 1'b1;
  endfunction

  function automatic int pick(int own, bit ql, bit qr);
    if (own == 1 && ql) return 1;
    if (own == 2 && qr) return 2;
    if (own == 2) return ql ? 1 : 0;
    if (own == 1) return qr ? 2 : 0;
    return ql ? 1 : (qr ? 2 : 0);
  endfunction

  task automatic check(logic act, logic exp, string tag, string side);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s rdata actual=%0b expected=%0b at %0t", tag, side, act, exp, $time);
    end
  endtask

  task automatic step(input logic ls, lw, lr, input logic [2:0] la, input logic ld,
                      input logic rs, rw, rr, input logic [2:0] ra, input logic rd,
                      input string tag);
    l_sel = ls; l_wr = lw; l_rd = lr; l_addr = la; l_wdata = ld;
    r_sel = rs; r_wr = rw; r_rd = rr; r_addr = ra; r_wdata = rd;
    if (ls && lr) exp_l = view(m_own[la], 1);
    if (rs && rr) exp_r = view(m_own[ra], 2);
    if (ls && lw) m_ql[la] = ~ld;
    if (rs && rw) m_qr[ra] = ~rd;
    if (ls && lw) m_own[la] = pick(m_own[la], m_ql[la], m_qr[la]);
    if (rs && rw && !(ls && lw && la == ra)) m_own[ra] = pick(m_own[ra], m_ql[ra], m_qr[ra]);
    @(negedge clk);
    check(l_rdata, exp_l, tag, "left");
    check(r_rdata, exp_r, tag, "right");
  endtask

  task automatic wl(logic [2:0] a, logic d, string tag);
    step(1, 1, 0, a, d, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr_r(logic [2:0] a, logic d, string tag);
    step(0, 0, 0, 0, 0, 1, 1, 0, a, d, tag);
  endtask
  task automatic rboth(logic [2:0] a, string tag);
    step(1, 0, 1, a, 0, 1, 0, 1, a, 0, tag);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {l_sel, l_wr, l_rd, l_wdata, r_sel, r_wr, r_rd, r_wdata} = '0;
    l_addr = '0; r_addr = '0;
    for (int i = 0; i < 8; i++) begin m_own[i] = 0; m_ql[i] = 0; m_qr[i] = 0; end
    exp_l = 1'b1; exp_r = 1'b1;
    repeat (3) @(negedge clk);
    check(l_rdata, 1'b1, "R1", "left");
    check(r_rdata, 1'b1, "R1", "right");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R3: all free after reset
    for (int a = 0; a < 8; a++) rboth(3'(a), "R1");

    // R2: grant to left, then to right elsewhere
    wl(3'd2, 0, "R2");
    rboth(3'd2, "R2");
    wr_r(3'd5, 0, "R2");
    rboth(3'd5, "R2");
    // R10: neighbours untouched
    rboth(3'd3, "R10");
    // R4: right requests left-held 2
    wr_r(3'd2, 0, "R4");
    rboth(3'd2, "R4");
    // R9: read in same cycle as write sees old state
    step(1, 1, 1, 3'd2, 1, 1, 0, 1, 3'd2, 0, "R9");
    // R5: handover happened, visible now
    rboth(3'd2, "R5");
    // R9: hold without read
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    // R6: right releases, no waiter
    wr_r(3'd2, 1, "R6");
    rboth(3'd2, "R6");
    rboth(3'd2, "R3");
    // R7: left waits on 5, cancels, right releases -> free
    wl(3'd5, 0, "R7");
    wl(3'd5, 1, "R7");
    wr_r(3'd5, 1, "R7");
    rboth(3'd5, "R7");
    // R8: tie on free 6
    step(1, 1, 0, 3'd6, 0, 1, 1, 0, 3'd6, 0, "R8");
    rboth(3'd6, "R8");
    wl(3'd6, 1, "R8");
    rboth(3'd6, "R8");
    wr_r(3'd6, 1, "R8");
    // R11: strobes without select
    step(0, 1, 0, 3'd1, 0, 0, 1, 0, 3'd1, 0, "R11");
    rboth(3'd1, "R11");

    // random traffic
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] la, ra;
      la = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 2);
      ra = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 2);
      step(1'($urandom % 8 != 0), 1'($urandom), 1'($urandom), la, 1'($urandom),
           1'($urandom % 8 != 0), 1'($urandom), 1'($urandom), ra, 1'($urandom),
           "R5 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule